// File: doc/BRIEF.md
# Double-Width Rate-Match Elastic Buffer

This block is an elastic buffer between two clock domains. It takes 20-bit words on a receive-side write clock and hands them out on a local read clock. Each word is two 10-bit byte lanes, `[19:10]` and `[9:0]`. The two clocks run at nearly the same frequency, with a small offset between them. The buffer takes up that offset without ever pushing back on the writer or stalling the reader.

If the buffer is about to overflow, the incoming word is discarded whole, so both lanes go together. If it has nothing to deliver, it emits a filler word in place of data. The filler word carries the K30.7 control code in both lanes. A one-cycle flag in each clock domain marks every discard and every filler.

The stream follows a valid-only convention, with no ready signal in either direction. The writer presents a word by raising `wr_valid`, and that word is either stored or discarded in the same cycle. After reset the read side produces a word on every read-clock cycle, and `rd_valid` stays high. The two pointers cross between the domains as Gray codes, each through a two-flop synchronizer.

Top module: `dw_rate_match_fifo`

## Requirements
- R1: Every word that is not discarded appears exactly once on `rd_data`, in the order it was written, and its two lanes stay together.
- R2: A word presented while the write side sees an occupancy of `DEPTH-2` or more is discarded, and it never appears on the read side. Storing it would leave only one free slot, which is the full condition. Any other presented word is stored.
- R3: `wr_full` is high for exactly one write-clock cycle, the cycle after each discarded word was sampled. That is the cycle in which a following word would be presented. `wr_full` is never high after a cycle with `wr_valid` low.
- R4: On a read-clock edge with no synchronized word available, `rd_data` becomes the filler `20'h7F9FE`, which is `{10'h1FE,10'h1FE}`. In each lane, bit 9 is 0, bit 8 is the control flag set to 1, and bits [7:0] are `8'hFE`.
- R5: `rd_empty` is high exactly in the read cycles whose `rd_data` is a filler word.
- R6: A filler does not move the read pointer. The first data word after one or more fillers is the next word in write order, and nothing is lost.
- R7: `rd_valid` is low during reset and high on every read cycle after reset. No input on either side can stall the stream.
- R8: While `rst_n` is low, `wr_full`, `rd_empty` and `rd_valid` are 0 and both pointers are cleared. The first read cycle after reset delivers a filler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Receive-side write clock |
| rd_clk | input | 1 | Local read clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| wr_valid | input | 1 | A word is presented on `wr_data` this write cycle |
| wr_data | input | 20 | Incoming word, two 10-bit lanes |
| wr_full | output | 1 | One-cycle pulse after a discarded word |
| rd_valid | output | 1 | High on every read cycle after reset |
| rd_data | output | 20 | Delivered word or K30.7 filler pair |
| rd_empty | output | 1 | High while `rd_data` holds a filler |

## Verification
The assertions check four rules on every cycle. The occupancy seen by the writer never exceeds `DEPTH-2`. A full pulse never coincides with a write-pointer step. A filler always carries the K30.7 code and leaves the read pointer unmoved. A data word always moves the read pointer by exactly one.

Other behaviours can only be shown by the bench's scenarios. One is that the discarded word is precisely the one before the full pulse. Another is that the surviving words arrive once each and in order across the fast-writer, slow-writer and gapped-writer phases. A third is that fillers appear where underflow truly happens.

// File: rtl/rmf_pkg.sv
package rmf_pkg;
  localparam int LANE_W = 10;
  localparam int WORD_W = 2 * LANE_W;
  localparam logic [LANE_W-1:0] FILL_LANE = 10'h1FE;
  localparam logic [WORD_W-1:0] FILL_WORD = {FILL_LANE, FILL_LANE};
endpackage

// File: rtl/rmf_gray_sync.sv
module rmf_gray_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] meta_q, gray_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      gray_q <= '0;
    end else begin
      meta_q <= gray_in;
      gray_q <= meta_q;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_dec
    assign bin_out[i] = ^gray_q[W-1:i];
  end
endmodule

// File: rtl/rmf_store.sv
module rmf_store #(
  parameter int DEPTH = 16,
  parameter int W     = 20,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] cells [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/rmf_wr_side.sv
module rmf_wr_side #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          wclk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [PW-1:0] rbin_s,
  output logic [PW-1:0] wbin,
  output logic [PW-1:0] wgray,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic          full
);
  localparam logic [PW-1:0] ACCEPT_LIMIT = PW'(DEPTH - 2);

  logic [PW-1:0] occ, wbin_nxt;
  logic          accept;

  assign occ      = wbin - rbin_s;
  assign accept   = in_valid && (occ < ACCEPT_LIMIT);
  assign wbin_nxt = wbin + PW'(accept);
  assign we       = accept;
  assign waddr    = wbin[AW-1:0];

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
      full  <= 1'b0;
    end else begin
      wbin  <= wbin_nxt;
      wgray <= wbin_nxt ^ (wbin_nxt >> 1);
      full  <= in_valid && !accept;
    end
  end
endmodule

// File: rtl/rmf_rd_side.sv
module rmf_rd_side #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic                       rclk,
  input  logic                       rst_n,
  input  logic [PW-1:0]              wbin_s,
  input  logic [rmf_pkg::WORD_W-1:0] mem_data,
  output logic [PW-1:0]              rbin,
  output logic [PW-1:0]              rgray,
  output logic [AW-1:0]              raddr,
  output logic [rmf_pkg::WORD_W-1:0] out_data,
  output logic                       out_valid,
  output logic                       out_empty
);
  logic          avail;
  logic [PW-1:0] rbin_nxt;

  assign avail    = (wbin_s != rbin);
  assign rbin_nxt = rbin + PW'(avail);
  assign raddr    = rbin[AW-1:0];

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin      <= '0;
      rgray     <= '0;
      out_data  <= '0;
      out_valid <= 1'b0;
      out_empty <= 1'b0;
    end else begin
      rbin      <= rbin_nxt;
      rgray     <= rbin_nxt ^ (rbin_nxt >> 1);
      out_valid <= 1'b1;
      out_empty <= !avail;
      out_data  <= avail ? mem_data : rmf_pkg::FILL_WORD;
    end
  end
endmodule

// File: rtl/dw_rate_match_fifo.sv
module dw_rate_match_fifo #(
  parameter int DEPTH = 16
) (
  input  logic        wr_clk,
  input  logic        rd_clk,
  input  logic        rst_n,
  input  logic        wr_valid,
  input  logic [19:0] wr_data,
  output logic        wr_full,
  output logic        rd_valid,
  output logic [19:0] rd_data,
  output logic        rd_empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [PW-1:0] wr_ptr, wr_gray, wr_view_rptr;
  logic [PW-1:0] rd_ptr, rd_gray, rd_view_wptr;
  logic          mem_we;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic [19:0]   mem_rdata;

  rmf_wr_side #(.DEPTH(DEPTH)) wr_i (
    .wclk(wr_clk), .rst_n(rst_n), .in_valid(wr_valid), .rbin_s(wr_view_rptr),
    .wbin(wr_ptr), .wgray(wr_gray), .we(mem_we), .waddr(mem_waddr), .full(wr_full)
  );

  rmf_gray_sync #(.W(PW)) r2w_i (
    .clk(wr_clk), .rst_n(rst_n), .gray_in(rd_gray), .bin_out(wr_view_rptr)
  );

  rmf_gray_sync #(.W(PW)) w2r_i (
    .clk(rd_clk), .rst_n(rst_n), .gray_in(wr_gray), .bin_out(rd_view_wptr)
  );

  rmf_store #(.DEPTH(DEPTH), .W(rmf_pkg::WORD_W)) mem_i (
    .wclk(wr_clk), .we(mem_we), .waddr(mem_waddr), .wdata(wr_data),
    .raddr(mem_raddr), .rdata(mem_rdata)
  );

  rmf_rd_side #(.DEPTH(DEPTH)) rd_i (
    .rclk(rd_clk), .rst_n(rst_n), .wbin_s(rd_view_wptr), .mem_data(mem_rdata),
    .rbin(rd_ptr), .rgray(rd_gray), .raddr(mem_raddr), .out_data(rd_data),
    .out_valid(rd_valid), .out_empty(rd_empty)
  );
endmodule

// File: rtl/rmf_checker.sv
module rmf_checker #(
  parameter int DEPTH = 16,
  localparam int PW   = $clog2(DEPTH) + 1
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic          wr_full,
  input logic          rd_valid,
  input logic          rd_empty,
  input logic [19:0]   rd_data,
  input logic [PW-1:0] wr_ptr,
  input logic [PW-1:0] wr_view_rptr,
  input logic [PW-1:0] rd_ptr
);
  p_occ_cap_r2: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (PW'(wr_ptr - wr_view_rptr) <= PW'(DEPTH - 2)));

  p_full_no_store_r2: assert property (@(posedge wr_clk) disable iff (!rst_n)
    wr_full |-> (wr_ptr == $past(wr_ptr)));

  p_full_after_valid_r3: assert property (@(posedge wr_clk) disable iff (!rst_n)
    wr_full |-> $past(wr_valid));

  p_fill_code_r4: assert property (@(posedge rd_clk) disable iff (!rst_n)
    rd_empty |-> (rd_data == rmf_pkg::FILL_WORD));

  p_fill_holds_ptr_r6: assert property (@(posedge rd_clk) disable iff (!rst_n)
    rd_empty |-> (rd_ptr == $past(rd_ptr)));

  p_data_steps_ptr_r1: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (rd_valid && !rd_empty) |-> (rd_ptr == PW'($past(rd_ptr) + PW'(1))));
endmodule

bind dw_rate_match_fifo rmf_checker #(.DEPTH(DEPTH)) chk_i (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_valid(wr_valid),
  .wr_full(wr_full), .rd_valid(rd_valid), .rd_empty(rd_empty), .rd_data(rd_data),
  .wr_ptr(wr_ptr), .wr_view_rptr(wr_view_rptr), .rd_ptr(rd_ptr)
);

// File: tb/dw_rate_match_fifo_tb_top.sv
`timescale 1ns/1ps
module dw_rate_match_fifo_tb_top;
  localparam logic [19:0] FILL = 20'h7F9FE;

  logic wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic [19:0] wr_data = '0;
  logic wr_full, rd_valid, rd_empty;
  logic [19:0] rd_data;

  real wr_half = 4.95;
  int  n_chk = 0, n_bad = 0, n_drop = 0, n_fill = 0;
  bit  rd_chk_en = 1'b0, done = 1'b0, prev_valid = 1'b0;
  int  seq = 0;
  logic [19:0] exp_q[$];

  always #(wr_half) wr_clk = ~wr_clk;
  always #5 rd_clk = ~rd_clk;

  dw_rate_match_fifo dut_i (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_valid(wr_valid),
    .wr_data(wr_data), .wr_full(wr_full), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_empty(rd_empty)
  );

  task automatic check(input bit ok, input string req, input logic [19:0] act, input logic [19:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // Reference model, read side: compared on every read clock.
  always @(negedge rd_clk) begin
    if (rd_chk_en) begin
      check(rd_valid == 1'b1, "R7 rd_valid", {19'b0, rd_valid}, 20'h1);
      if (rd_empty) begin
        n_fill++;
        check(rd_data == FILL, "R4/R5 filler word", rd_data, FILL);
      end else if (exp_q.size() == 0) begin
        check(1'b0, "R1/R2 data with nothing accepted", rd_data, FILL);
      end else begin
        logic [19:0] e;
        e = exp_q.pop_front();
        check(rd_data == e, "R1/R6 data order", rd_data, e);
      end
    end
  end

  // Reference model, write side: a full pulse retires the last presented word.
  task automatic wr_cycles(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      bit v;
      @(negedge wr_clk);
      if (wr_full) begin
        n_drop++;
        check(prev_valid, "R3 full after valid cycle", {19'b0, wr_full}, 20'h0);
        if (prev_valid && exp_q.size() > 0) void'(exp_q.pop_back());
      end
      v = (gap == 0) || (i % gap == 0);
      wr_valid = v;
      if (v) begin
        wr_data = {~seq[9:0], seq[9:0]};
        exp_q.push_back(wr_data);
        seq++;
      end
      prev_valid = v;
    end
  endtask

  initial begin
    #1_000_000;
    check(1'b0, "watchdog expired", 20'h0, 20'h1);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge rd_clk);
    // R8: reset state
    check(wr_full == 1'b0, "R8 wr_full in reset", {19'b0, wr_full}, 20'h0);
    check(rd_empty == 1'b0, "R8 rd_empty in reset", {19'b0, rd_empty}, 20'h0);
    check(rd_valid == 1'b0, "R7/R8 rd_valid in reset", {19'b0, rd_valid}, 20'h0);
    #2 rst_n = 1'b1;
    @(negedge rd_clk);
    // R8: first read cycle after reset is a filler
    check(rd_empty && rd_data == FILL, "R8 first word filler", rd_data, FILL);
    rd_chk_en = 1'b1;
    // Fast writer: overflow and discards
    wr_half = 4.95;
    wr_cycles(4000, 0);
    // Slow writer: underflow and fillers between data
    wr_half = 5.05;
    wr_cycles(3000, 0);
    // Gapped writer: frequent underflow, resume after filler
    wr_half = 5.0;
    wr_cycles(600, 3);
    wr_cycles(60, 5000);
    @(negedge wr_clk);
    if (wr_full) begin
      n_drop++;
      if (exp_q.size() > 0) void'(exp_q.pop_back());
    end
    wr_valid = 1'b0;
    repeat (40) @(negedge rd_clk);
    rd_chk_en = 1'b0;
    check(n_drop > 0, "R2/R3 discards seen in fast phase", 20'(n_drop), 20'h1);
    check(n_fill > 0, "R4/R6 fillers seen in slow phase", 20'(n_fill), 20'h1);
    check(exp_q.size() == 0, "R1 all accepted words delivered", 20'(exp_q.size()), 20'h0);
    finish_run();
  end
endmodule